// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave-side command engine for a small byte-addressed nonvolatile memory on a four-wire serial bus. Each selection starts with one 8-bit command byte, sent most significant bit first. The block acts on six command codes. Any other code is dropped, and so is the rest of that selection. Depending on the command, the block collects a 16-bit address and data bytes, or it shifts memory bytes or the status byte back out.

The memory array, the page buffer, the write-enable latch and the protection policy all sit outside the block. It reaches them through single-cycle strobes and a registered read request. All serial inputs are resynchronised into the system clock domain, which must run at least eight times faster than the serial clock. Bus modes 0 and 3 behave the same way: a bit is taken on each rising serial-clock edge and the next output bit is launched on each falling edge. A pause input freezes the shift engine between two edges.

Top module: `spi_mem_cmd_if`

## Requirements
- R1: While `ssel_n` is high, `sdo_en` is low. Every low period of `ssel_n` restarts decoding at the command byte.
- R2: Input bits are taken on rising `sclk` edges and output bits change on falling `sclk` edges, most significant bit first. Both idle levels of `sclk` (mode 0 low, mode 3 high) work.
- R3: Command 0x06 gives one `wel_set` pulse and 0x04 gives one `wel_clr` pulse. A byte outside the set {0x01,0x02,0x03,0x04,0x05,0x06} gives no strobe, and every later byte in that selection is ignored. At most one of the four control strobes is high in any cycle.
- R4: Command 0x03 takes a 16-bit address, most significant byte first. Only the low ADDR_W bits are kept. The block then pulses `mem_rd_req` with `mem_addr` set; `mem_rd_data` must be valid in the next cycle. The returned bytes are shifted out.
- R5: During a 0x03 read, the address steps by one after each byte leaves the block, and it wraps from the top of the array to 0.
- R6: Command 0x05 shifts out `status_i` again and again until deselect. `status_i` is sampled again at the start of each output byte.
- R7: After command 0x02 and its address, each complete data byte gives one `mem_wr_stb` carrying that byte and the current `mem_addr`. `mem_addr` increases by one in the following cycle.
- R8: Command 0x01 gives one `stat_wr_stb` carrying the first complete byte after it. Later bytes are ignored.
- R9: If `busy_i` is high when the command byte completes, every command except 0x05 is ignored.
- R10: Bits after the last complete byte at deselect are discarded and produce no strobe.
- R11: Taking `pause_n` low while `sclk` is low turns `sdo_en` off and makes `sclk` edges ignored. Raising `pause_n` again while `sclk` is low resumes the transfer with its state intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ssel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| pause_n | input | 1 | Transfer pause, active low |
| sdo | output | 1 | Serial data to the host |
| sdo_en | output | 1 | Output driver enable for `sdo` |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte to return |
| mem_addr | output | ADDR_W | Current byte address |
| mem_rd_req | output | 1 | Read request; data expected next cycle |
| mem_rd_data | input | 8 | Read data |
| mem_wr_stb | output | 1 | One received write byte |
| mem_wr_data | output | 8 | Write byte |
| stat_wr_stb | output | 1 | Status write byte received |
| stat_wr_data | output | 8 | Status write byte |
| wel_set | output | 1 | Write-enable set request |
| wel_clr | output | 1 | Write-enable clear request |

## Verification
The properties assume that the serial clock is slow against the system clock, so that each half period spans more cycles than the synchroniser depth. They also assume that `pause_n` changes only while `sclk` is low. With these inputs no edge is lost and a paused engine never sees a half-counted edge. The stimulus holds every `sclk` level for eight system cycles and moves `sdi` and `pause_n` only in the low phase. `ssel_n` changes only with `sclk` at its idle level.

// File: rtl/spi_mem_pkg.sv
// Shared command codes and the command state type for the serial memory front end.
package spi_mem_pkg;

    localparam logic [7:0] CMD_WEN_SET = 8'h06;
    localparam logic [7:0] CMD_WEN_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD = 8'h05;
    localparam logic [7:0] CMD_STAT_WR = 8'h01;
    localparam logic [7:0] CMD_MEM_RD  = 8'h03;
    localparam logic [7:0] CMD_MEM_WR  = 8'h02;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_STAT_OUT,
        ST_STAT_IN,
        ST_DROP
    } cmd_st_e;

endpackage

// File: rtl/spi_in_sync.sv
// Input conditioner: resynchronises select, serial clock, data and pause into clk,
// detects serial clock edges and tracks the paused state.
// Assumes the serial clock half period exceeds SYNC_STAGES+1 system cycles and SYNC_STAGES >= 2.
module spi_in_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ssel_n,
    input  logic sclk,
    input  logic sdi,
    input  logic pause_n,
    output logic sel,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s,
    output logic held
);
    localparam int CW = 4 * SYNC_STAGES;
    localparam logic [3:0] IDLE_V = 4'b1001;

    logic [CW-1:0] chain;
    logic [3:0]    synced;
    logic          sclk_d;

    // Shift raw pins through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {SYNC_STAGES{IDLE_V}};
        else        chain <= {chain[CW-5:0], ssel_n, sclk, sdi, pause_n};
    end

    assign synced = chain[CW-1 -: 4];
    assign sel    = ~synced[3];
    assign sdi_s  = synced[1];

    // Remember the previous synchronised serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= synced[2];
    end

    // Pause state changes only while the serial clock is low; deselect clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)          held <= 1'b0;
        else if (!sel)       held <= 1'b0;
        else if (!synced[2]) held <= ~synced[0];
    end

    assign sclk_rise = sel & ~held &  synced[2] & ~sclk_d;
    assign sclk_fall = sel & ~held & ~synced[2] &  sclk_d;

endmodule

// File: rtl/spi_cmd_fsm.sv
// Command engine: assembles bytes from rising edges, decodes the command byte,
// collects the address and drives the memory, status and write-enable strobes.
// Assumes mem_rd_data returns one cycle after mem_rd_req; requires 8 < ADDR_W <= 16.
module spi_cmd_fsm
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sclk_rise,
    input  logic              sdi_s,
    input  logic              busy_i,
    input  logic              tx_load,
    output cmd_st_e           state,
    output logic [2:0]        bitcnt,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_req,
    output logic              wr_stb,
    output logic [7:0]        wr_data,
    output logic              stat_stb,
    output logic [7:0]        stat_data,
    output logic              wel_set,
    output logic              wel_clr
);
    localparam int HI_W = ADDR_W - 8;

    logic [6:0]      shreg;
    logic [7:0]      rx_byte;
    logic            byte_done;
    logic [HI_W-1:0] adr_hi;
    logic            is_read;

    assign rx_byte   = {shreg, sdi_s};
    assign byte_done = sclk_rise && (bitcnt == 3'd7);

    // Sequence the command: bit assembly, decode, address capture and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_CMD;
            bitcnt    <= '0;
            shreg     <= '0;
            addr      <= '0;
            adr_hi    <= '0;
            is_read   <= 1'b0;
            rd_req    <= 1'b0;
            wr_stb    <= 1'b0;
            wr_data   <= '0;
            stat_stb  <= 1'b0;
            stat_data <= '0;
            wel_set   <= 1'b0;
            wel_clr   <= 1'b0;
        end else begin
            rd_req   <= 1'b0;
            wr_stb   <= 1'b0;
            stat_stb <= 1'b0;
            wel_set  <= 1'b0;
            wel_clr  <= 1'b0;
            if (wr_stb) addr <= addr + 1'b1;
            if (!sel) begin
                state  <= ST_CMD;
                bitcnt <= '0;
            end else begin
                if (sclk_rise) begin
                    shreg  <= rx_byte[6:0];
                    bitcnt <= bitcnt + 1'b1;
                end
                if (byte_done) begin
                    case (state)
                        ST_CMD: begin
                            if (busy_i && rx_byte != CMD_STAT_RD) begin
                                state <= ST_DROP;
                            end else begin
                                case (rx_byte)
                                    CMD_WEN_SET: begin wel_set <= 1'b1; state <= ST_DROP; end
                                    CMD_WEN_CLR: begin wel_clr <= 1'b1; state <= ST_DROP; end
                                    CMD_STAT_RD: state <= ST_STAT_OUT;
                                    CMD_STAT_WR: state <= ST_STAT_IN;
                                    CMD_MEM_RD:  begin is_read <= 1'b1; state <= ST_ADR_HI; end
                                    CMD_MEM_WR:  begin is_read <= 1'b0; state <= ST_ADR_HI; end
                                    default:     state <= ST_DROP;
                                endcase
                            end
                        end
                        ST_ADR_HI: begin
                            adr_hi <= rx_byte[HI_W-1:0];
                            state  <= ST_ADR_LO;
                        end
                        ST_ADR_LO: begin
                            addr <= {adr_hi, rx_byte};
                            if (is_read) begin
                                rd_req <= 1'b1;
                                state  <= ST_RD_DATA;
                            end else begin
                                state  <= ST_WR_DATA;
                            end
                        end
                        ST_WR_DATA: begin
                            wr_stb  <= 1'b1;
                            wr_data <= rx_byte;
                        end
                        ST_STAT_IN: begin
                            stat_stb  <= 1'b1;
                            stat_data <= rx_byte;
                            state     <= ST_DROP;
                        end
                        default: ;
                    endcase
                end
                if (tx_load && state == ST_RD_DATA) begin
                    addr   <= addr + 1'b1;
                    rd_req <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_shift.sv
// Output shifter: on each active falling edge either loads a new byte (at a byte
// boundary) or shifts the next bit onto sdo. Assumes byte_i is stable at the boundary.
module spi_tx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_fall,
    input  logic       active,
    input  logic       at_bound,
    input  logic [7:0] byte_i,
    output logic       sdo,
    output logic       load_o
);
    logic [6:0] rest;

    // Launch output bits on falling serial clock edges, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            rest   <= '0;
            load_o <= 1'b0;
        end else begin
            load_o <= 1'b0;
            if (sclk_fall && active) begin
                if (at_bound) begin
                    sdo    <= byte_i[7];
                    rest   <= byte_i[6:0];
                    load_o <= 1'b1;
                end else begin
                    sdo  <= rest[6];
                    rest <= {rest[5:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_mem_cmd_if.sv
// Top of the serial memory command front end: joins the input conditioner, the
// command engine and the output shifter, and keeps a one-byte read prefetch.
// Assumes the system clock runs at least 8x the serial clock.
module spi_mem_cmd_if
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ssel_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              pause_n,
    output logic              sdo,
    output logic              sdo_en,
    input  logic              busy_i,
    input  logic [7:0]        status_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_req,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_stb,
    output logic [7:0]        mem_wr_data,
    output logic              stat_wr_stb,
    output logic [7:0]        stat_wr_data,
    output logic              wel_set,
    output logic              wel_clr
);
    logic       sel, sclk_rise, sclk_fall, sdi_s, held;
    logic       tx_load, out_state, rd_pend;
    logic [2:0] bitcnt;
    logic [7:0] rd_buf, tx_byte;
    cmd_st_e    state;

    spi_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ssel_n    (ssel_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .pause_n   (pause_n),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .held      (held)
    );

    spi_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sdi_s     (sdi_s),
        .busy_i    (busy_i),
        .tx_load   (tx_load),
        .state     (state),
        .bitcnt    (bitcnt),
        .addr      (mem_addr),
        .rd_req    (mem_rd_req),
        .wr_stb    (mem_wr_stb),
        .wr_data   (mem_wr_data),
        .stat_stb  (stat_wr_stb),
        .stat_data (stat_wr_data),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr)
    );

    // Capture read data in the cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_buf  <= '0;
        end else begin
            rd_pend <= mem_rd_req;
            if (rd_pend) rd_buf <= mem_rd_data;
        end
    end

    assign out_state = (state == ST_RD_DATA) || (state == ST_STAT_OUT);
    assign tx_byte   = (state == ST_STAT_OUT) ? status_i : rd_buf;
    assign sdo_en    = sel && !held && out_state;

    spi_tx_shift u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_fall (sclk_fall),
        .active    (out_state),
        .at_bound  (bitcnt == 3'd0),
        .byte_i    (tx_byte),
        .sdo       (sdo),
        .load_o    (tx_load)
    );

endmodule

// File: rtl/spi_mem_cmd_if_chk.sv
// Property checker for spi_mem_cmd_if, attached by bind. Assumes serial inputs obey
// the slow-clock and pause-while-low rules stated for the block.
module spi_mem_cmd_if_chk
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ssel_n,
    input logic              sdo_en,
    input logic              mem_wr_stb,
    input logic              stat_wr_stb,
    input logic              wel_set,
    input logic              wel_clr,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              held,
    input cmd_st_e           state,
    input logic [2:0]        bitcnt
);
    logic [3:0] desel_cnt;

    // Count cycles that select has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              desel_cnt <= '0;
        else if (!ssel_n)        desel_cnt <= '0;
        else if (desel_cnt != 4'hF) desel_cnt <= desel_cnt + 1'b1;
    end

    AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_cnt > 4'(SYNC_STAGES)) |-> !sdo_en); // R1

    AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr_stb, stat_wr_stb, wel_set, wel_clr})); // R3

    AST_RD_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req); // R4

    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_stb |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R7

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> ($stable(state) && $stable(bitcnt))); // R11

endmodule

bind spi_mem_cmd_if spi_mem_cmd_if_chk #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ssel_n      (ssel_n),
    .sdo_en      (sdo_en),
    .mem_wr_stb  (mem_wr_stb),
    .stat_wr_stb (stat_wr_stb),
    .wel_set     (wel_set),
    .wel_clr     (wel_clr),
    .mem_rd_req  (mem_rd_req),
    .mem_addr    (mem_addr),
    .held        (held),
    .state       (state),
    .bitcnt      (bitcnt)
);

// File: tb/test_spi_mem_cmd_if.sv
// Self-checking bench: a command vector table, then directed transfers.
module test_spi_mem_cmd_if;
    localparam int ADDR_W = 10;
    localparam int HALF   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ssel_n = 1'b1, sclk = 1'b0, sdi = 1'b0, pause_n = 1'b1;
    logic busy_i = 1'b0;
    logic [7:0] status_i = 8'h00;
    logic sdo, sdo_en, mem_rd_req, mem_wr_stb, stat_wr_stb, wel_set, wel_clr;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_rd_data, mem_wr_data, stat_wr_data;

    int n_chk = 0, n_fail = 0;
    int n_set = 0, n_clr = 0, n_wr = 0, n_stat = 0;
    logic [7:0] last_stat;
    bit done = 1'b0;

    logic [7:0] mem [1024];
    logic       mval [1024];

    always #5 clk = ~clk;

    spi_mem_cmd_if #(.ADDR_W(ADDR_W)) i_spi_mem_cmd_if (
        .clk(clk), .rst_n(rst_n), .ssel_n(ssel_n), .sclk(sclk), .sdi(sdi),
        .pause_n(pause_n), .sdo(sdo), .sdo_en(sdo_en), .busy_i(busy_i),
        .status_i(status_i), .mem_addr(mem_addr), .mem_rd_req(mem_rd_req),
        .mem_rd_data(mem_rd_data), .mem_wr_stb(mem_wr_stb), .mem_wr_data(mem_wr_data),
        .stat_wr_stb(stat_wr_stb), .stat_wr_data(stat_wr_data),
        .wel_set(wel_set), .wel_clr(wel_clr)
    );

    function automatic logic [7:0] init_byte(input int a);
        return 8'(a * 7 + 3);
    endfunction

    // Memory model: one-cycle read latency, write on strobe.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mval[i] <= 1'b0;
            mem_rd_data <= '0;
        end else begin
            if (mem_wr_stb) begin
                mem[mem_addr]  <= mem_wr_data;
                mval[mem_addr] <= 1'b1;
            end
            if (mem_rd_req)
                mem_rd_data <= mval[mem_addr] ? mem[mem_addr] : init_byte(int'(mem_addr));
        end
    end

    // Strobe counters.
    always @(posedge clk) begin
        if (rst_n) begin
            if (wel_set)     n_set++;
            if (wel_clr)     n_clr++;
            if (mem_wr_stb)  n_wr++;
            if (stat_wr_stb) begin n_stat++; last_stat = stat_wr_data; end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_begin(input bit m3);
        sclk = m3;
        wt(4);
        ssel_n = 1'b0;
        wt(HALF);
    endtask

    task automatic sel_end(input bit m3);
        if (!m3) begin sclk = 1'b0; wt(HALF); end
        ssel_n = 1'b1;
        wt(2 * HALF);
    endtask

    // Shift n bits of tx (MSB first); optional pause inside bit pause_at.
    task automatic xfer(input logic [7:0] tx, input int n, input int pause_at, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            sclk = 1'b0;
            sdi  = tx[i];
            wt(HALF);
            if (i == pause_at) begin
                pause_n = 1'b0;
                wt(HALF);
                chk("R11", "sdo_en during pause", 32'(sdo_en), 32'h0);
                sdi = ~sdi;
                sclk = 1'b1; wt(HALF); sclk = 1'b0; wt(HALF);
                sclk = 1'b1; wt(HALF); sclk = 1'b0; wt(HALF);
                chk("R11", "sdo_en still paused", 32'(sdo_en), 32'h0);
                sdi = tx[i];
                pause_n = 1'b1;
                wt(HALF);
            end
            rx[i] = sdo_en ? sdo : 1'bx;
            sclk = 1'b1;
            wt(HALF);
        end
    endtask

    // Vector table: {busy, command, expected set pulses, expected clear pulses}.
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 8'h06, 1'b1, 1'b0},
        {1'b0, 8'h04, 1'b0, 1'b1},
        {1'b1, 8'h06, 1'b0, 1'b0},
        {1'b1, 8'h04, 1'b0, 1'b0},
        {1'b0, 8'hFF, 1'b0, 1'b0},
        {1'b0, 8'h86, 1'b0, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b0},
        {1'b0, 8'h07, 1'b0, 1'b0}
    };

    initial begin
        logic [7:0] rx, rx2, rx3;
        int s0, c0, w0, t0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // Reset state
        chk("R1", "sdo_en after reset", 32'(sdo_en), 32'h0);
        chk("R3", "strobes after reset", 32'({wel_set, wel_clr, mem_wr_stb, stat_wr_stb, mem_rd_req}), 32'h0);

        // Table walk: command byte followed by a second 0x06 in the same selection
        for (int v = 0; v < 8; v++) begin
            busy_i = VEC[v][10];
            s0 = n_set; c0 = n_clr;
            sel_begin(1'b0);
            xfer(VEC[v][9:2], 8, -1, rx);
            xfer(8'h06, 8, -1, rx);
            sel_end(1'b0);
            busy_i = 1'b0;
            chk(VEC[v][10] ? "R9" : "R3", "set pulses", 32'(n_set - s0), 32'(VEC[v][1]));
            chk(VEC[v][10] ? "R9" : "R3", "clear pulses", 32'(n_clr - c0), 32'(VEC[v][0]));
        end

        // R6 R2: status streaming in mode 0, resampled at each byte
        status_i = 8'hA5;
        sel_begin(1'b0);
        xfer(8'h05, 8, -1, rx);
        xfer(8'h00, 8, -1, rx);
        status_i = 8'h3C;
        xfer(8'h00, 8, -1, rx2);
        sel_end(1'b0);
        chk("R6", "status byte 1", 32'(rx), 32'hA5);
        chk("R6", "status byte 2 resampled", 32'(rx2), 32'h3C);
        chk("R1", "sdo_en after deselect", 32'(sdo_en), 32'h0);

        // R2: mode 3
        status_i = 8'h96;
        sel_begin(1'b1);
        xfer(8'h05, 8, -1, rx);
        xfer(8'h00, 8, -1, rx);
        sel_end(1'b1);
        chk("R2", "status in mode 3", 32'(rx), 32'h96);

        // R9: status read still works while busy; write ignored while busy
        busy_i = 1'b1;
        status_i = 8'h01;
        sel_begin(1'b0);
        xfer(8'h05, 8, -1, rx);
        xfer(8'h00, 8, -1, rx);
        sel_end(1'b0);
        chk("R9", "status while busy", 32'(rx), 32'h01);
        w0 = n_wr;
        sel_begin(1'b0);
        xfer(8'h02, 8, -1, rx); xfer(8'h00, 8, -1, rx); xfer(8'h30, 8, -1, rx); xfer(8'h77, 8, -1, rx);
        sel_end(1'b0);
        busy_i = 1'b0;
        chk("R9", "write ignored while busy", 32'(n_wr - w0), 32'h0);

        // R4 R5: read near top of array wraps to 0
        sel_begin(1'b0);
        xfer(8'h03, 8, -1, rx); xfer(8'h03, 8, -1, rx); xfer(8'hFE, 8, -1, rx);
        xfer(8'h00, 8, -1, rx); xfer(8'h00, 8, -1, rx2); xfer(8'h00, 8, -1, rx3);
        sel_end(1'b0);
        chk("R4", "read 0x3FE", 32'(rx), 32'(init_byte(12'h3FE)));
        chk("R5", "read 0x3FF", 32'(rx2), 32'(init_byte(12'h3FF)));
        chk("R5", "read wraps to 0", 32'(rx3), 32'(init_byte(0)));

        // R4: upper address bits ignored
        sel_begin(1'b0);
        xfer(8'h03, 8, -1, rx); xfer(8'hFC, 8, -1, rx); xfer(8'h05, 8, -1, rx);
        xfer(8'h00, 8, -1, rx);
        sel_end(1'b0);
        chk("R4", "upper address bits ignored", 32'(rx), 32'(init_byte(5)));

        // R7 R10: two bytes written, trailing partial byte dropped
        w0 = n_wr;
        sel_begin(1'b0);
        xfer(8'h02, 8, -1, rx); xfer(8'h01, 8, -1, rx); xfer(8'h20, 8, -1, rx);
        xfer(8'hDE, 8, -1, rx); xfer(8'hAD, 8, -1, rx); xfer(8'hFF, 3, -1, rx);
        sel_end(1'b0);
        chk("R10", "write strobes with partial byte", 32'(n_wr - w0), 32'h2);
        sel_begin(1'b0);
        xfer(8'h03, 8, -1, rx); xfer(8'h01, 8, -1, rx); xfer(8'h20, 8, -1, rx);
        xfer(8'h00, 8, -1, rx); xfer(8'h00, 8, -1, rx2); xfer(8'h00, 8, -1, rx3);
        sel_end(1'b0);
        chk("R7", "written byte 0x120", 32'(rx), 32'hDE);
        chk("R7", "written byte 0x121", 32'(rx2), 32'hAD);
        chk("R10", "0x122 untouched", 32'(rx3), 32'(init_byte(12'h122)));

        // R10: partial command byte produces nothing
        s0 = n_set;
        sel_begin(1'b0);
        xfer(8'h06, 5, -1, rx);
        sel_end(1'b0);
        chk("R10", "partial command", 32'(n_set - s0), 32'h0);

        // R8: status write takes only the first byte
        t0 = n_stat;
        sel_begin(1'b0);
        xfer(8'h01, 8, -1, rx); xfer(8'h8C, 8, -1, rx); xfer(8'h11, 8, -1, rx);
        sel_end(1'b0);
        chk("R8", "status write count", 32'(n_stat - t0), 32'h1);
        chk("R8", "status write data", 32'(last_stat), 32'h8C);

        // R11: pause in the middle of a read byte
        sel_begin(1'b0);
        xfer(8'h03, 8, -1, rx); xfer(8'h00, 8, -1, rx); xfer(8'h40, 8, -1, rx);
        xfer(8'h00, 8, 4, rx); xfer(8'h00, 8, -1, rx2);
        sel_end(1'b0);
        chk("R11", "paused byte intact", 32'(rx), 32'(init_byte(12'h040)));
        chk("R11", "byte after pause", 32'(rx2), 32'(init_byte(12'h041)));

        // R1: abort mid-read, next selection restarts at the command byte
        status_i = 8'h5A;
        sel_begin(1'b0);
        xfer(8'h03, 8, -1, rx); xfer(8'h00, 8, -1, rx); xfer(8'h00, 4, -1, rx);
        sel_end(1'b0);
        sel_begin(1'b0);
        xfer(8'h05, 8, -1, rx); xfer(8'h00, 8, -1, rx);
        sel_end(1'b0);
        chk("R1", "restart after abort", 32'(rx), 32'h5A);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule